// File: doc/BRIEF.md
# VGA Timing Generator

This block turns a supplied pixel clock into the raster timing of a VGA-style display. A horizontal counter steps once per pixel clock. A vertical counter steps once per finished line. From the two counters the block drives a horizontal sync, a vertical sync and a display-enable flag. It also drives the column and row of the pixel now being scanned, so that an external image source can supply the right colour on time.

Every mode figure is a parameter: active length, front porch, sync width and back porch on each axis, plus a separate polarity for each sync. The defaults give a 1920x1200, 60 Hz mode, which needs a pixel clock near 193.16 MHz. An optional test-pattern stage uses the coordinates and the enable to produce a blue box in the top-left corner of the screen. The rest of the active area is yellow, and blanking is black. The colours come out on three 8-bit channels.

All outputs are registered, so sync, enable, coordinates and colour change on the same clock edge. The reset is synchronous and active high.

Top module: `vga_timing_gen`

## Requirements
- R1: Counting from the first edge after reset release (edge 0), the outputs at edge k show horizontal position k mod (H_ACT+H_FP+H_SW+H_BP). The vertical position advances by one each time the horizontal position wraps from its last value to 0. The vertical position itself wraps to 0 after its last back-porch line.
- R2: de_o is 1 exactly when the horizontal position is below H_ACT and the vertical position is below V_ACT.
- R3: The horizontal sync is asserted for horizontal positions H_ACT+H_FP through H_ACT+H_FP+H_SW-1. Asserted means hsync_o = H_POL, with 1 = active high and 0 = active low. At every other position hsync_o is the inverse of H_POL.
- R4: The vertical sync is asserted on lines V_ACT+V_FP through V_ACT+V_FP+V_SW-1, for the whole of each such line. Asserted means vsync_o = V_POL, with 1 = active high and 0 = active low. vsync_o changes level only on the edge that shows horizontal position 0.
- R5: During the active region col_o and row_o equal the horizontal and vertical positions. In blanking, col_o keeps its last active value (H_ACT-1). row_o keeps V_ACT-1 through vertical blanking.
- R6: At every edge with rst high, the block does four things: de_o goes to 0, col_o and row_o go to 0, both syncs go to their inactive levels, and both counters return to position 0. The first edge with rst low shows pixel (0,0).
- R7: With the pattern enabled, colour is red=00 green=00 blue=FF where column < BOX_W and row < BOX_H. It is red=FF green=FF blue=00 elsewhere in the active area. All three channels are 0 whenever de_o is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_o | output | 1 | Horizontal sync, polarity set by H_POL |
| vsync_o | output | 1 | Vertical sync, polarity set by V_POL |
| de_o | output | 1 | Display enable |
| col_o | output | $clog2(H_ACT) | Current column coordinate |
| row_o | output | $clog2(V_ACT) | Current row coordinate |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |

## Verification
The bench runs a reduced mode with 8 active, 2 front porch, 3 sync and 2 back porch per axis. A second copy has both polarities flipped, so a design that ignored a polarity setting, or tied one sync to the other's polarity, would mismatch on one of the two copies. The checks go after the points where positions wrap and the sync edges sit one position past a porch. An off-by-one comparison there would shift a pulse or widen it by a cycle, and a vertical counter stepped on the wrong horizontal position would move vsync away from the start of the line. Coordinates are compared through blanking, where a design that kept counting would show values past the active width. A reset pulse in the middle of an active line checks that enable, coordinates and colour clear at once and that the next frame restarts at pixel (0,0).

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } pix_t;

  localparam pix_t PIX_BLACK  = '{r: 8'h00, g: 8'h00, b: 8'h00};
  localparam pix_t PIX_BLUE   = '{r: 8'h00, g: 8'h00, b: 8'hFF};
  localparam pix_t PIX_YELLOW = '{r: 8'hFF, g: 8'hFF, b: 8'h00};

  function automatic int unsigned axis_total(int unsigned act, int unsigned fp,
                                             int unsigned sw, int unsigned bp);
    return act + fp + sw + bp;
  endfunction

endpackage

// File: rtl/vga_axis_counter.sv
module vga_axis_counter #(
  parameter int unsigned ACT = 1920,
  parameter int unsigned FP  = 128,
  parameter int unsigned SW  = 208,
  parameter int unsigned BP  = 336,
  localparam int unsigned TOTAL = vga_timing_pkg::axis_total(ACT, FP, SW, BP),
  localparam int unsigned CW    = $clog2(TOTAL)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          adv,
  output logic [CW-1:0] cnt,
  output logic          last,
  output logic          active,
  output logic          sync
);

  localparam logic [CW-1:0] LAST_POS   = CW'(TOTAL - 1);
  localparam logic [CW-1:0] SYNC_START = CW'(ACT + FP);
  localparam logic [CW-1:0] SYNC_END   = CW'(ACT + FP + SW);
  localparam logic [CW-1:0] ACT_END    = CW'(ACT);

  assign last   = (cnt == LAST_POS);
  assign active = (cnt < ACT_END);
  assign sync   = (cnt >= SYNC_START) && (cnt < SYNC_END);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (adv) begin
      if (last) cnt <= '0;
      else      cnt <= cnt + 1'b1;
    end
  end

  // R1: wrap back to the first active position after the last back-porch slot
  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt == LAST_POS) |=> (cnt == '0));

  // R1: single step otherwise
  a_r1_single_step: assert property (@(posedge clk) disable iff (rst)
    (adv && cnt != LAST_POS) |=> (cnt == $past(cnt) + 1'b1));

  // R1: no movement without an advance
  a_r1_hold_idle: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(cnt));

endmodule

// File: rtl/vga_test_pattern.sv
module vga_test_pattern #(
  parameter int unsigned HCW    = 12,
  parameter int unsigned VCW    = 11,
  parameter int unsigned BOX_W  = 600,
  parameter int unsigned BOX_H  = 478,
  parameter bit          ENABLE = 1'b1
) (
  input  logic [HCW-1:0]       hpos,
  input  logic [VCW-1:0]       vpos,
  input  logic                 visible,
  output vga_timing_pkg::pix_t pix
);
  import vga_timing_pkg::*;

  generate
    if (ENABLE) begin : g_pattern
      logic in_box;
      assign in_box = (32'(hpos) < BOX_W) && (32'(vpos) < BOX_H);
      assign pix    = !visible ? PIX_BLACK : (in_box ? PIX_BLUE : PIX_YELLOW);
    end else begin : g_no_pattern
      logic unused;
      assign unused = ^{hpos, vpos, visible};
      assign pix    = PIX_BLACK;
    end
  endgenerate

endmodule

// File: rtl/vga_timing_gen.sv
module vga_timing_gen #(
  parameter int unsigned H_ACT      = 1920,
  parameter int unsigned H_FP       = 128,
  parameter int unsigned H_SW       = 208,
  parameter int unsigned H_BP       = 336,
  parameter int unsigned V_ACT      = 1200,
  parameter int unsigned V_FP       = 1,
  parameter int unsigned V_SW       = 3,
  parameter int unsigned V_BP       = 38,
  parameter bit          H_POL      = 1'b0,
  parameter bit          V_POL      = 1'b1,
  parameter int unsigned BOX_W      = 600,
  parameter int unsigned BOX_H      = 478,
  parameter bit          PATTERN_EN = 1'b1,
  localparam int unsigned H_TOT = vga_timing_pkg::axis_total(H_ACT, H_FP, H_SW, H_BP),
  localparam int unsigned V_TOT = vga_timing_pkg::axis_total(V_ACT, V_FP, V_SW, V_BP),
  localparam int unsigned HCW   = $clog2(H_TOT),
  localparam int unsigned VCW   = $clog2(V_TOT),
  localparam int unsigned XW    = $clog2(H_ACT),
  localparam int unsigned YW    = $clog2(V_ACT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          hsync_o,
  output logic          vsync_o,
  output logic          de_o,
  output logic [XW-1:0] col_o,
  output logic [YW-1:0] row_o,
  output logic [7:0]    red_o,
  output logic [7:0]    green_o,
  output logic [7:0]    blue_o
);
  import vga_timing_pkg::*;

  logic [HCW-1:0] hcnt;
  logic [VCW-1:0] vcnt;
  logic           h_last, h_act, h_sync;
  logic           v_last, v_act, v_sync;
  logic           v_unused_last;
  pix_t           pix_c;

  vga_axis_counter #(.ACT(H_ACT), .FP(H_FP), .SW(H_SW), .BP(H_BP)) u_hcnt (
    .clk(clk), .rst(rst), .adv(1'b1),
    .cnt(hcnt), .last(h_last), .active(h_act), .sync(h_sync)
  );

  vga_axis_counter #(.ACT(V_ACT), .FP(V_FP), .SW(V_SW), .BP(V_BP)) u_vcnt (
    .clk(clk), .rst(rst), .adv(h_last),
    .cnt(vcnt), .last(v_last), .active(v_act), .sync(v_sync)
  );

  assign v_unused_last = v_last;

  vga_test_pattern #(
    .HCW(HCW), .VCW(VCW), .BOX_W(BOX_W), .BOX_H(BOX_H), .ENABLE(PATTERN_EN)
  ) u_pattern (
    .hpos(hcnt), .vpos(vcnt), .visible(h_act && v_act), .pix(pix_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hsync_o <= ~H_POL;
      vsync_o <= ~V_POL;
      de_o    <= 1'b0;
      col_o   <= '0;
      row_o   <= '0;
      red_o   <= '0;
      green_o <= '0;
      blue_o  <= '0;
    end else begin
      hsync_o <= h_sync ? H_POL : ~H_POL;
      vsync_o <= v_sync ? V_POL : ~V_POL;
      de_o    <= h_act && v_act;
      if (h_act) col_o <= hcnt[XW-1:0];
      if (v_act) row_o <= vcnt[YW-1:0];
      red_o   <= pix_c.r;
      green_o <= pix_c.g;
      blue_o  <= pix_c.b;
    end
  end

  // R4: vertical sync moves only on the edge that presents horizontal position 0
  a_r4_vsync_line_aligned: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && vsync_o != $past(vsync_o)) |-> (hcnt == HCW'(1)));

  // R5: column held through horizontal blanking
  a_r5_col_hold: assert property (@(posedge clk) disable iff (rst)
    (hcnt >= HCW'(H_ACT)) |=> $stable(col_o));

  // R6: reset clears enable and coordinates
  a_r6_reset_clears: assert property (@(posedge clk)
    rst |=> (!de_o && col_o == '0 && row_o == '0));

  // R7: black outside the enabled area
  a_r7_black_blanking: assert property (@(posedge clk) disable iff (rst)
    !de_o |-> (red_o == 8'h00 && green_o == 8'h00 && blue_o == 8'h00));

endmodule

// File: tb/vga_timing_gen_test.sv
module vga_timing_gen_test;

  localparam int HA = 8, HF = 2, HS = 3, HB = 2;
  localparam int VA = 8, VF = 2, VS = 3, VB = 2;
  localparam int HT = HA + HF + HS + HB;
  localparam int VT = VA + VF + VS + VB;
  localparam int BW = 5, BH = 3;

  typedef struct {
    logic hs, vs, de, hs2, vs2;
    int col, row;
    logic [7:0] r, g, b;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic hs, vs, de, hs2, vs2, de2;
  logic [2:0] col, col2;
  logic [2:0] row, row2;
  logic [7:0] r, g, b, r2, g2, b2;

  vga_timing_gen #(
    .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB),
    .H_POL(1'b0), .V_POL(1'b1), .BOX_W(BW), .BOX_H(BH), .PATTERN_EN(1'b1)
  ) uut (
    .clk(clk), .rst(rst), .hsync_o(hs), .vsync_o(vs), .de_o(de),
    .col_o(col), .row_o(row), .red_o(r), .green_o(g), .blue_o(b)
  );

  vga_timing_gen #(
    .H_ACT(HA), .H_FP(HF), .H_SW(HS), .H_BP(HB),
    .V_ACT(VA), .V_FP(VF), .V_SW(VS), .V_BP(VB),
    .H_POL(1'b1), .V_POL(1'b0), .BOX_W(BW), .BOX_H(BH), .PATTERN_EN(1'b1)
  ) uut_inv (
    .clk(clk), .rst(rst), .hsync_o(hs2), .vsync_o(vs2), .de_o(de2),
    .col_o(col2), .row_o(row2), .red_o(r2), .green_o(g2), .blue_o(b2)
  );

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  int mh = 0, mv = 0, mcol = 0, mrow = 0;
  bit done = 1'b0;

  task automatic chk(string req, string what, int act, int expv);
    n_checks++;
    if (act != expv) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
    end
  endtask

  // driver: one clock, pushing the expected outputs of that edge
  task automatic tick();
    exp_t e;
    logic hsa, vsa;
    @(posedge clk);
    #1;
    if (rst) begin
      mh = 0; mv = 0; mcol = 0; mrow = 0;
      e.hs = 1'b1; e.vs = 1'b0; e.hs2 = 1'b0; e.vs2 = 1'b1;
      e.de = 1'b0; e.col = 0; e.row = 0;
      e.r = 8'h00; e.g = 8'h00; e.b = 8'h00;
    end else begin
      hsa = (mh >= HA + HF) && (mh < HA + HF + HS);
      vsa = (mv >= VA + VF) && (mv < VA + VF + VS);
      e.hs = ~hsa; e.hs2 = hsa;
      e.vs = vsa;  e.vs2 = ~vsa;
      e.de = (mh < HA) && (mv < VA);
      if (mh < HA) mcol = mh;
      if (mv < VA) mrow = mv;
      e.col = mcol; e.row = mrow;
      if (!e.de) begin
        e.r = 8'h00; e.g = 8'h00; e.b = 8'h00;
      end else if (mh < BW && mv < BH) begin
        e.r = 8'h00; e.g = 8'h00; e.b = 8'hFF;
      end else begin
        e.r = 8'hFF; e.g = 8'hFF; e.b = 8'h00;
      end
      if (mh == HT - 1) begin
        mh = 0;
        mv = (mv == VT - 1) ? 0 : mv + 1;
      end else begin
        mh = mh + 1;
      end
    end
    exp_q.push_back(e);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      chk("R3", "hsync (active low copy)", int'(hs), int'(e.hs));
      chk("R3", "hsync (active high copy)", int'(hs2), int'(e.hs2));
      chk("R4", "vsync (active high copy)", int'(vs), int'(e.vs));
      chk("R4", "vsync (active low copy)", int'(vs2), int'(e.vs2));
      chk("R2", "display enable", int'(de), int'(e.de));
      chk("R5", "column", int'(col), e.col);
      chk("R5", "row", int'(row), e.row);
      chk("R7", "red", int'(r), int'(e.r));
      chk("R7", "green", int'(g), int'(e.g));
      chk("R7", "blue", int'(b), int'(e.b));
    end
  end

  initial begin
    fork
      begin
        // R6: reset state held for a few edges
        run(4);
        @(negedge clk); rst = 1'b0;
        // R1: two full frames plus part of a third
        run(2 * HT * VT + 2 * HT + 3);
        // R6: reset in the middle of active line 2
        @(negedge clk); rst = 1'b1;
        run(3);
        @(negedge clk); rst = 1'b0;
        // R1 R6: restart from pixel (0,0) and run through a frame wrap
        run(HT * VT + HT + 5);
        @(negedge clk);
        @(negedge clk);
        done = 1'b1;
      end
      begin
        #(20 * 5000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule